// File: doc/BRIEF.md
# Keystream Bus Decryption Bridge

The bridge sits on the path from a processor-side register port to a secure peripheral. Words written into its data window arrive encrypted; each one is XORed with a 32-bit keystream word and sent to the target as plaintext on a simple master write channel. Reads from the data window go to the target, and the returned word is XORed with the next keystream word before it goes back to the processor. Encryption and decryption are the same XOR, so software holding the same key and IV produces matching keystream on its side.

The keystream generator sits outside the block on a start/ready/valid port. Software opens a session by writing the session-start bit. The bridge then advances an IV counter that software tracks in step, sends the new IV to the generator with a one-cycle start pulse, and waits for the generator to report that initialisation is finished. Data traffic is held off until that happens. A control register window exposes a status word and the current IV counter value.

Top module: `ks_bus_bridge`

## Requirements
- R1: A write to the data window (address MSB = 1) is forwarded on the master write channel with address equal to the slave address minus its MSB and data equal to slave data XOR the keystream word presented at acceptance; that keystream word is consumed (`ks_req` pulses once).
- R2: A read from the data window (address MSB = 1) is issued on the master read channel with the same address mapping; the returned response is the target's data XOR the keystream word presented when the read was accepted, which is consumed.
- R3: A write to control index 0 (address MSB = 0, address bits [3:2] = 0) with data bit 0 = 1, accepted in idle or ready, raises `ks_start` for exactly one cycle, in the cycle after acceptance, with `ks_iv` already holding the incremented counter.
- R4: Data-window writes and reads are not accepted (ready held low) unless the controller is ready and `ks_valid` is high; while a session is initialising they stall.
- R5: The IV counter is 0 after reset and changes only by +1, once per accepted session start; the first session after reset uses IV 1.
- R6: A session start while the counter is all ones starts no session: no `ks_start`, counter unchanged, sticky error bit set, controller returns to idle.
- R7: Control index 0 reads the status word: bit 0 busy (loading, initialising or transferring), bit 1 ready, bit 2 IV error, all other bits 0. Index 1 reads the low bits of the IV counter, zero-extended.
- R8: A control write with data bit 0 = 0, or to any index other than 0, changes neither the state nor the counter.
- R9: A master write or read request stays asserted with stable address and data until its ready; only one master transfer is outstanding.
- R10: A slave read response stays valid with stable data until `s_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_wvalid | input | 1 | Slave write request |
| s_wready | output | 1 | Slave write accepted |
| s_waddr | input | ADDR_W | Slave write byte address |
| s_wdata | input | DW | Slave write data (ciphertext in data window) |
| s_arvalid | input | 1 | Slave read request |
| s_arready | output | 1 | Slave read accepted |
| s_araddr | input | ADDR_W | Slave read byte address |
| s_rvalid | output | 1 | Slave read response valid |
| s_rready | input | 1 | Slave read response taken |
| s_rdata | output | DW | Slave read data |
| m_wvalid | output | 1 | Master write request |
| m_wready | input | 1 | Target accepted the write |
| m_waddr | output | ADDR_W-1 | Master write address |
| m_wdata | output | DW | Master write data (plaintext) |
| m_arvalid | output | 1 | Master read request |
| m_arready | input | 1 | Target accepted the read |
| m_araddr | output | ADDR_W-1 | Master read address |
| m_rvalid | input | 1 | Target read data valid |
| m_rready | output | 1 | Bridge waits for target read data |
| m_rdata | input | DW | Target read data (plaintext) |
| ks_start | output | 1 | One-cycle pulse that starts generator initialisation |
| ks_iv | output | IV_W | IV for the session |
| ks_ready | input | 1 | Generator has finished initialisation |
| ks_req | output | 1 | Consume the current keystream word |
| ks_valid | input | 1 | Keystream word available |
| ks_word | input | DW | Keystream word |

## Verification
A controller stuck in the wrong state shows at the slave port within a cycle: data writes either go through during initialisation, which gives plaintext computed with a stale keystream, or stall forever, which the bench sees as a handshake that never completes. A keystream index that is out of step with the generator gives wrong plaintext on the very next master write or read response, because every expected value is rebuilt from the session IV and the word count. Counter or error-flag faults appear on the next status or counter read and on the IV carried by the next start pulse.

// File: rtl/bb_pkg.sv
// Shared types and constants for the keystream bus bridge.
// Assumes control register indices are taken from byte-address bits [3:2].
package bb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_IV,
        ST_INIT_WAIT,
        ST_READY,
        ST_XFER
    } bb_state_t;

    typedef enum logic [1:0] {
        XK_WR,
        XK_RD_ADDR,
        XK_RD_DATA
    } bb_xk_t;

    localparam logic [1:0] REG_CTRL = 2'd0;  // write: session start, read: status
    localparam logic [1:0] REG_IV   = 2'd1;  // read: IV counter low bits

    localparam int STAT_BUSY  = 0;
    localparam int STAT_READY = 1;
    localparam int STAT_IVERR = 2;

endpackage

// File: rtl/bb_iv_counter.sv
// Session IV counter. Steps by one on each accepted session start.
// At all ones it holds its value and raises a sticky error instead of wrapping.
// Assumes bump is a single-cycle pulse from the controller.
module bb_iv_counter #(
    parameter int IV_W = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bump,
    output logic [IV_W-1:0] iv,
    output logic            at_max,
    output logic            err
);

    // Flags the value from which one more step would wrap.
    always_comb at_max = &iv;

    // Advance the counter or latch the overflow error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv  <= '0;
            err <= 1'b0;
        end else if (bump) begin
            if (at_max) err <= 1'b1;
            else        iv  <= iv + 1'b1;
        end
    end

endmodule

// File: rtl/bb_ctrl.sv
// Session controller: accepts slave requests, sequences the keystream
// generator start-up and runs one master transfer at a time.
// Assumes the generator lowers ks_ready within the cycle after ks_start.
module bb_ctrl
    import bb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_wvalid,
    input  logic       w_is_data,
    input  logic [1:0] w_idx,
    input  logic       start_bit,
    input  logic       s_arvalid,
    input  logic       r_is_data,
    input  logic       rsp_busy,
    input  logic       ks_ready,
    input  logic       ks_valid,
    input  logic       m_wready,
    input  logic       m_arready,
    input  logic       m_rvalid,
    input  logic       iv_at_max,
    output logic       s_wready,
    output logic       s_arready,
    output logic       w_data_fire,
    output logic       r_data_fire,
    output logic       r_ctrl_fire,
    output logic       rsp_load_data,
    output logic       iv_bump,
    output logic       ks_start,
    output logic       ks_req,
    output logic       m_wvalid,
    output logic       m_arvalid,
    output logic       m_rready,
    output logic       busy,
    output logic       ready
);

    bb_state_t st, st_n;
    bb_xk_t    xk, xk_n;
    logic      w_fire, r_fire, start_fire, sess_ok;

    // Slave-side acceptance; data traffic only in READY with keystream present.
    always_comb begin
        sess_ok   = ks_valid && (st == ST_READY);
        s_wready  = w_is_data ? sess_ok : ((st == ST_IDLE) || (st == ST_READY));
        w_fire    = s_wvalid && s_wready;
        s_arready = r_is_data ? (sess_ok && !rsp_busy && !s_wvalid)
                              : (!rsp_busy && (st != ST_XFER));
        r_fire    = s_arvalid && s_arready;
        w_data_fire = w_fire && w_is_data;
        r_data_fire = r_fire && r_is_data;
        r_ctrl_fire = r_fire && !r_is_data;
        start_fire  = w_fire && !w_is_data && (w_idx == REG_CTRL) && start_bit;
        iv_bump     = start_fire;
        ks_req      = w_data_fire || r_data_fire;
    end

    // Next-state logic for the session and transfer sequence.
    always_comb begin
        st_n = st;
        xk_n = xk;
        case (st)
            ST_IDLE: begin
                if (start_fire) st_n = iv_at_max ? ST_IDLE : ST_LOAD_IV;
            end
            ST_LOAD_IV:   st_n = ST_INIT_WAIT;
            ST_INIT_WAIT: begin
                if (ks_ready) st_n = ST_READY;
            end
            ST_READY: begin
                if (start_fire) begin
                    st_n = iv_at_max ? ST_IDLE : ST_LOAD_IV;
                end else if (w_data_fire) begin
                    st_n = ST_XFER;
                    xk_n = XK_WR;
                end else if (r_data_fire) begin
                    st_n = ST_XFER;
                    xk_n = XK_RD_ADDR;
                end
            end
            ST_XFER: begin
                case (xk)
                    XK_WR:      if (m_wready)  st_n = ST_READY;
                    XK_RD_ADDR: if (m_arready) xk_n = XK_RD_DATA;
                    XK_RD_DATA: if (m_rvalid)  st_n = ST_READY;
                    default:    st_n = ST_READY;
                endcase
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            xk <= XK_WR;
        end else begin
            st <= st_n;
            xk <= xk_n;
        end
    end

    // Master-side and generator-side strobes decoded from state.
    always_comb begin
        ks_start      = (st == ST_LOAD_IV);
        m_wvalid      = (st == ST_XFER) && (xk == XK_WR);
        m_arvalid     = (st == ST_XFER) && (xk == XK_RD_ADDR);
        m_rready      = (st == ST_XFER) && (xk == XK_RD_DATA);
        rsp_load_data = m_rready && m_rvalid;
        busy          = (st == ST_LOAD_IV) || (st == ST_INIT_WAIT) || (st == ST_XFER);
        ready         = (st == ST_READY);
    end

endmodule

// File: rtl/bb_xor_path.sv
// Data path: XORs keystream into forwarded writes and returned reads,
// and holds the slave read response until it is taken.
// Assumes fire strobes from the controller are mutually consistent.
module bb_xor_path
    import bb_pkg::*;
#(
    parameter int DW   = 32,
    parameter int TA_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            w_data_fire,
    input  logic            r_data_fire,
    input  logic            r_ctrl_fire,
    input  logic            rsp_load_data,
    input  logic [TA_W-1:0] s_waddr_lo,
    input  logic [DW-1:0]   s_wdata,
    input  logic [TA_W-1:0] s_araddr_lo,
    input  logic [1:0]      r_idx,
    input  logic [DW-1:0]   ks_word,
    input  logic [DW-1:0]   m_rdata,
    input  logic [DW-1:0]   status_word,
    input  logic [DW-1:0]   iv_word,
    input  logic            s_rready,
    output logic [TA_W-1:0] m_waddr,
    output logic [DW-1:0]   m_wdata,
    output logic [TA_W-1:0] m_araddr,
    output logic            s_rvalid,
    output logic [DW-1:0]   s_rdata
);

    logic [DW-1:0] kw_q;
    logic [DW-1:0] ctrl_val;

    // Selects the control register returned on a control-window read.
    always_comb begin
        case (r_idx)
            REG_CTRL: ctrl_val = status_word;
            REG_IV:   ctrl_val = iv_word;
            default:  ctrl_val = '0;
        endcase
    end

    // Captures the outgoing master request and the keystream kept for reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_waddr  <= '0;
            m_wdata  <= '0;
            m_araddr <= '0;
            kw_q     <= '0;
        end else begin
            if (w_data_fire) begin
                m_waddr <= s_waddr_lo;
                m_wdata <= s_wdata ^ ks_word;
            end
            if (r_data_fire) begin
                m_araddr <= s_araddr_lo;
                kw_q     <= ks_word;
            end
        end
    end

    // Slave response register: loaded once, cleared by the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else if (rsp_load_data) begin
            s_rvalid <= 1'b1;
            s_rdata  <= m_rdata ^ kw_q;
        end else if (r_ctrl_fire) begin
            s_rvalid <= 1'b1;
            s_rdata  <= ctrl_val;
        end else if (s_rvalid && s_rready) begin
            s_rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/ks_bus_bridge.sv
// Top of the keystream bus bridge. Decodes slave addresses into a control
// window (MSB = 0) and a data window (MSB = 1), ties the controller, IV
// counter and XOR data path together. Assumes ADDR_W >= 5 and DW >= 3.
module ks_bus_bridge
    import bb_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 12,
    parameter int IV_W   = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [ADDR_W-1:0] s_waddr,
    input  logic [DW-1:0]     s_wdata,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DW-1:0]     s_rdata,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [ADDR_W-2:0] m_waddr,
    output logic [DW-1:0]     m_wdata,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-2:0] m_araddr,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DW-1:0]     m_rdata,
    output logic              ks_start,
    output logic [IV_W-1:0]   ks_iv,
    input  logic              ks_ready,
    output logic              ks_req,
    input  logic              ks_valid,
    input  logic [DW-1:0]     ks_word
);

    localparam int TA_W = ADDR_W - 1;

    logic          w_is_data, r_is_data;
    logic [1:0]    w_idx, r_idx;
    logic          w_data_fire, r_data_fire, r_ctrl_fire, rsp_load_data;
    logic          iv_bump, iv_at_max, iv_err;
    logic          busy, ready;
    logic [DW-1:0] status_word, iv_word;

    // Window and register-index decode of the slave addresses.
    always_comb begin
        w_is_data = s_waddr[ADDR_W-1];
        r_is_data = s_araddr[ADDR_W-1];
        w_idx     = s_waddr[3:2];
        r_idx     = s_araddr[3:2];
    end

    // Status word assembly.
    always_comb begin
        status_word             = '0;
        status_word[STAT_BUSY]  = busy;
        status_word[STAT_READY] = ready;
        status_word[STAT_IVERR] = iv_err;
    end

    // Fit the IV counter into one data word.
    generate
        if (IV_W >= DW) begin : g_iv_trunc
            assign iv_word = ks_iv[DW-1:0];
        end else begin : g_iv_pad
            assign iv_word = {{(DW-IV_W){1'b0}}, ks_iv};
        end
    endgenerate

    bb_iv_counter #(.IV_W(IV_W)) u_iv (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump   (iv_bump),
        .iv     (ks_iv),
        .at_max (iv_at_max),
        .err    (iv_err)
    );

    bb_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .s_wvalid      (s_wvalid),
        .w_is_data     (w_is_data),
        .w_idx         (w_idx),
        .start_bit     (s_wdata[0]),
        .s_arvalid     (s_arvalid),
        .r_is_data     (r_is_data),
        .rsp_busy      (s_rvalid),
        .ks_ready      (ks_ready),
        .ks_valid      (ks_valid),
        .m_wready      (m_wready),
        .m_arready     (m_arready),
        .m_rvalid      (m_rvalid),
        .iv_at_max     (iv_at_max),
        .s_wready      (s_wready),
        .s_arready     (s_arready),
        .w_data_fire   (w_data_fire),
        .r_data_fire   (r_data_fire),
        .r_ctrl_fire   (r_ctrl_fire),
        .rsp_load_data (rsp_load_data),
        .iv_bump       (iv_bump),
        .ks_start      (ks_start),
        .ks_req        (ks_req),
        .m_wvalid      (m_wvalid),
        .m_arvalid     (m_arvalid),
        .m_rready      (m_rready),
        .busy          (busy),
        .ready         (ready)
    );

    bb_xor_path #(.DW(DW), .TA_W(TA_W)) u_path (
        .clk           (clk),
        .rst_n         (rst_n),
        .w_data_fire   (w_data_fire),
        .r_data_fire   (r_data_fire),
        .r_ctrl_fire   (r_ctrl_fire),
        .rsp_load_data (rsp_load_data),
        .s_waddr_lo    (s_waddr[TA_W-1:0]),
        .s_wdata       (s_wdata),
        .s_araddr_lo   (s_araddr[TA_W-1:0]),
        .r_idx         (r_idx),
        .ks_word       (ks_word),
        .m_rdata       (m_rdata),
        .status_word   (status_word),
        .iv_word       (iv_word),
        .s_rready      (s_rready),
        .m_waddr       (m_waddr),
        .m_wdata       (m_wdata),
        .m_araddr      (m_araddr),
        .s_rvalid      (s_rvalid),
        .s_rdata       (s_rdata)
    );

endmodule

// File: rtl/bb_checker.sv
// Protocol and session checks for ks_bus_bridge, attached by bind.
module bb_checker #(
    parameter int DW     = 32,
    parameter int ADDR_W = 12,
    parameter int IV_W   = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_wvalid,
    input logic              s_wready,
    input logic [ADDR_W-1:0] s_waddr,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [DW-1:0]     s_rdata,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic [ADDR_W-2:0] m_waddr,
    input logic [DW-1:0]     m_wdata,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic [ADDR_W-2:0] m_araddr,
    input logic              ks_start,
    input logic [IV_W-1:0]   ks_iv,
    input logic              ks_req,
    input logic              ks_valid,
    input logic              iv_err
);

    logic past_ok;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_data_write_consumes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wvalid && s_wready && s_waddr[ADDR_W-1]) |-> ks_req);

    p_start_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ks_start |=> !ks_start);

    p_keystream_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ks_req |-> ks_valid);

    p_iv_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(ks_iv)) |-> (ks_iv == $past(ks_iv) + 1'b1));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iv_err |=> iv_err);

    p_mwrite_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_waddr)));

    p_mread_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    p_single_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_wvalid && m_arvalid));

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

endmodule

bind ks_bus_bridge bb_checker #(.DW(DW), .ADDR_W(ADDR_W), .IV_W(IV_W)) u_bb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_waddr   (s_waddr),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rdata   (s_rdata),
    .m_wvalid  (m_wvalid),
    .m_wready  (m_wready),
    .m_waddr   (m_waddr),
    .m_wdata   (m_wdata),
    .m_arvalid (m_arvalid),
    .m_arready (m_arready),
    .m_araddr  (m_araddr),
    .ks_start  (ks_start),
    .ks_iv     (ks_iv),
    .ks_req    (ks_req),
    .ks_valid  (ks_valid),
    .iv_err    (iv_err)
);

// File: tb/tb_ks_bus_bridge.sv
module tb_ks_bus_bridge;

    localparam int DW       = 32;
    localparam int ADDR_W   = 12;
    localparam int IV_W     = 4;
    localparam int INIT_CYC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic              s_wvalid = 0, s_arvalid = 0, s_rready = 0;
    logic [ADDR_W-1:0] s_waddr = '0, s_araddr = '0;
    logic [DW-1:0]     s_wdata = '0;
    logic              s_wready, s_arready, s_rvalid;
    logic [DW-1:0]     s_rdata;
    logic              m_wvalid, m_arvalid, m_rready;
    logic              m_wready = 0, m_arready = 0, m_rvalid = 0;
    logic [ADDR_W-2:0] m_waddr, m_araddr;
    logic [DW-1:0]     m_wdata, m_rdata = '0;
    logic              ks_start, ks_req;
    logic [IV_W-1:0]   ks_iv;
    logic              ks_ready = 0;
    logic              ks_valid;
    logic [DW-1:0]     ks_word;

    ks_bus_bridge #(.DW(DW), .ADDR_W(ADDR_W), .IV_W(IV_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_waddr(s_waddr), .s_wdata(s_wdata),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_waddr(m_waddr), .m_wdata(m_wdata),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
        .ks_start(ks_start), .ks_iv(ks_iv), .ks_ready(ks_ready),
        .ks_req(ks_req), .ks_valid(ks_valid), .ks_word(ks_word)
    );

    int n_chk = 0, n_fail = 0;
    int starts = 0, wcount = 0;
    logic [IV_W-1:0]   g_iv = '0;
    logic [31:0]       g_idx = '0;
    int                g_icnt = 0;
    logic [ADDR_W-2:0] last_wa = '0;
    logic [DW-1:0]     last_wd = '0;
    logic [IV_W-1:0]   exp_iv = '0;
    logic [31:0]       exp_idx = '0;

    function automatic logic [31:0] kfun(input logic [31:0] iv, input logic [31:0] idx);
        return (iv * 32'h9E3779B1) ^ {idx[15:0], idx[15:0]} ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] rdfun(input logic [ADDR_W-2:0] a);
        return 32'hC0DE0000 ^ {21'b0, a};
    endfunction

    // Keystream generator model: initialises for INIT_CYC cycles after start.
    assign ks_valid = ks_ready;
    assign ks_word  = kfun({28'b0, g_iv}, g_idx);
    always @(posedge clk) begin
        if (!rst_n) begin
            ks_ready <= 1'b0; g_icnt <= 0; g_idx <= '0; g_iv <= '0;
        end else if (ks_start) begin
            starts <= starts + 1; g_iv <= ks_iv; g_idx <= '0;
            ks_ready <= 1'b0; g_icnt <= INIT_CYC;
        end else begin
            if (g_icnt != 0) begin
                g_icnt <= g_icnt - 1;
                if (g_icnt == 1) ks_ready <= 1'b1;
            end
            if (ks_req && ks_valid) g_idx <= g_idx + 1;
        end
    end

    // Target model: one-cycle ready, read data one cycle after address.
    always @(posedge clk) begin
        m_wready  <= m_wvalid && !m_wready;
        m_arready <= m_arvalid && !m_arready;
        m_rvalid  <= m_arvalid && m_arready;
        m_rdata   <= rdfun(m_araddr);
        if (m_wvalid && m_wready) begin
            wcount <= wcount + 1; last_wa <= m_waddr; last_wd <= m_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic s_write(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d, output int stall);
        stall = 0;
        s_wvalid = 1; s_waddr = a; s_wdata = d;
        while (!s_wready && stall < 1000) begin @(negedge clk); stall++; end
        @(negedge clk);
        s_wvalid = 0;
    endtask

    task automatic s_read(input logic [ADDR_W-1:0] a, output logic [DW-1:0] d);
        int guard = 0;
        s_arvalid = 1; s_araddr = a;
        while (!s_arready && guard < 1000) begin @(negedge clk); guard++; end
        @(negedge clk);
        s_arvalid = 0; s_rready = 1;
        while (!s_rvalid && guard < 1000) begin @(negedge clk); guard++; end
        d = s_rdata;
        @(negedge clk);
        s_rready = 0;
    endtask

    task automatic wait_ready();
        logic [DW-1:0] st;
        for (int i = 0; i < 50; i++) begin
            s_read(12'h000, st);
            if (st[1]) break;
        end
    endtask

    task automatic open_session(input string tag);
        int st; int s0;
        s0 = starts;
        s_write(12'h000, 32'h1, st);
        wait_ready();
        exp_iv = exp_iv + 1; exp_idx = 0;
        check({tag, " start pulse"}, starts - s0, 1);
        check({tag, " iv"}, {28'b0, g_iv}, {28'b0, exp_iv});
    endtask

    task automatic data_write(input string tag, input logic [10:0] off, input logic [31:0] ct,
                              input logic [31:0] pt_exp);
        int st; int w0; int guard = 0;
        w0 = wcount;
        s_write({1'b1, off}, ct, st);
        while (wcount == w0 && guard < 50) begin @(negedge clk); guard++; end
        check({tag, " plaintext"}, last_wd, pt_exp);
        check({tag, " address"}, {21'b0, last_wa}, {21'b0, off});
        exp_idx++;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        check("R9 reset m_wvalid", {31'b0, m_wvalid}, 0);
        check("R10 reset s_rvalid", {31'b0, s_rvalid}, 0);
        check("R3 reset ks_start", {31'b0, ks_start}, 0);
        s_read(12'h000, d); check("R7 reset status", d, 0);
        s_read(12'h004, d); check("R5 reset iv", d, 0);
    endtask

    task automatic t_first_session();
        int st; logic [DW-1:0] d; int s0;
        s0 = starts;
        s_write(12'h000, 32'h1, st);
        s_read(12'h000, d);
        check("R7 busy during init", d, 32'h1);
        wait_ready();
        exp_iv = 1; exp_idx = 0;
        check("R3 one start pulse", starts - s0, 1);
        check("R5 first iv", {28'b0, g_iv}, 32'h1);
        s_read(12'h000, d); check("R7 ready status", d, 32'h2);
        s_read(12'h004, d); check("R7 iv register", d, 32'h1);
        // ciphertext built from plaintext gives plaintext back
        data_write("R1 w0", 11'h010, 32'hDEADBEEF ^ kfun(1, 0), 32'hDEADBEEF);
        data_write("R1 w1", 11'h7FC, 32'h01234567, 32'h01234567 ^ kfun(1, 1));
    endtask

    task automatic t_read();
        logic [DW-1:0] d;
        s_read({1'b1, 11'h024}, d);
        check("R2 read decrypt", d, rdfun(11'h024) ^ kfun({28'b0, exp_iv}, exp_idx));
        exp_idx++;
        s_read({1'b1, 11'h100}, d);
        check("R2 second read", d, rdfun(11'h100) ^ kfun({28'b0, exp_iv}, exp_idx));
        exp_idx++;
    endtask

    task automatic t_backpressure();
        int st; int w0; int guard = 0;
        s_write(12'h000, 32'h1, st);
        exp_iv = exp_iv + 1; exp_idx = 0;
        w0 = wcount;
        s_write({1'b1, 11'h040}, 32'h55AA55AA, st);
        n_chk++;
        if (st < INIT_CYC) begin
            n_fail++;
            $display("FAIL R4 stall: actual %0d expected >= %0d", st, INIT_CYC);
        end
        while (wcount == w0 && guard < 50) begin @(negedge clk); guard++; end
        check("R4 first word after init", last_wd, 32'h55AA55AA ^ kfun({28'b0, exp_iv}, 0));
        exp_idx++;
    endtask

    task automatic t_rekey();
        open_session("R5 rekey");
        data_write("R1 rekey w0", 11'h010, 32'hDEADBEEF, 32'hDEADBEEF ^ kfun({28'b0, exp_iv}, 0));
    endtask

    task automatic t_ignored();
        int st; int s0; logic [DW-1:0] d;
        s0 = starts;
        s_write(12'h000, 32'h0, st);
        s_write(12'h008, 32'h1, st);
        s_write(12'h004, 32'hFFFFFFFF, st);
        repeat (3) @(negedge clk);
        check("R8 no start", starts - s0, 0);
        s_read(12'h000, d); check("R8 still ready", d, 32'h2);
        s_read(12'h004, d); check("R8 iv unchanged", d, {28'b0, exp_iv});
        data_write("R8 keystream intact", 11'h0, 32'h0, kfun({28'b0, exp_iv}, exp_idx));
    endtask

    task automatic t_overflow();
        int st; int s0; logic [DW-1:0] d;
        while (exp_iv != 4'hF) begin
            s_write(12'h000, 32'h1, st);
            wait_ready();
            exp_iv = exp_iv + 1;
        end
        check("R5 iv at max", {28'b0, g_iv}, 32'hF);
        s0 = starts;
        s_write(12'h000, 32'h1, st);
        repeat (3) @(negedge clk);
        check("R6 no start at max", starts - s0, 0);
        s_read(12'h000, d); check("R6 error idle status", d, 32'h4);
        s_read(12'h004, d); check("R6 iv held", d, 32'hF);
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_session();
        t_read();
        t_backpressure();
        t_rekey();
        t_ignored();
        t_overflow();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule